// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block watches exclusive loads and stores from several requesters and decides whether each exclusive store is allowed to reach memory. It holds reservation bits, not addresses. Each requester has one local reservation for private addresses and one share of a single global reservation for the shared window. An exclusive load sets the reservation for the region its address falls in. A later exclusive store writes only if that reservation is still held, and it reports one status bit. Software retries a load-modify-store loop until the status reads 0.

A small byte-addressed backing memory is built in, so the block can be exercised on its own. Each cycle, every requester may present one request. The response appears on the next cycle. Ordinary reads and writes go through without touching any reservation. Malformed requests are rejected with an error flag.

Top module: `excl_monitor`

## Requirements
- R1: An exclusive load (op 2) returns the memory bytes at its address, little-endian and zero-extended to 32 bits (size 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). It sets the issuer's reservation for the region of the address. The response comes exactly one cycle after the request.
- R2: An exclusive store (op 3) whose reservation is held writes its data, reports rsp_fail = 0 and drops that reservation, so a second store without a new load fails.
- R3: An exclusive store whose reservation is not held writes nothing and reports rsp_fail = 1.
- R4: Within one reservation the address is ignored: load A, load B, store B (succeeds), then store A fails.
- R5: A clear request (op 4) drops both of the issuer's reservations and writes nothing.
- R6: The exc_clr input bit of a requester drops only its local reservation. A global reservation survives it.
- R7: Addresses below SHARED_BASE (32 by default) use the issuer's own local reservation. Exclusive traffic from another requester to its own private addresses does not disturb it.
- R8: A successful exclusive store to the shared window (addresses at or above SHARED_BASE) drops the global reservation of every requester.
- R9: When several exclusive stores with held global reservations arrive in one cycle, the lowest-indexed requester writes and reports 0. The others report 1 and write nothing.
- R10: An ordinary read (op 0) returns data like R1. An ordinary write (op 1) writes its data. Neither changes any reservation.
- R11: A request with size 3, a misaligned address (size 1 with odd address, size 2 with address not a multiple of 4) or op 5 to 7 reports rsp_err = 1. It writes nothing and changes no reservation. An exclusive store rejected this way also reports rsp_fail = 1.
- R12: rsp_fail is 1 only in the response to an exclusive store. rsp_rdata is 0 for anything but a read or an exclusive load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NREQ | Request present, one bit per requester |
| req_op | input | 3*NREQ | Operation per requester: 0 read, 1 write, 2 exclusive load, 3 exclusive store, 4 clear |
| req_size | input | 2*NREQ | Access size code per requester |
| req_addr | input | AW*NREQ | Byte address per requester |
| req_wdata | input | 32*NREQ | Write data per requester, low bytes used |
| exc_clr | input | NREQ | Exception entry or return, drops local reservation |
| rsp_vld | output | NREQ | Response present, one cycle after request |
| rsp_rdata | output | 32*NREQ | Read data for reads and exclusive loads |
| rsp_fail | output | NREQ | Exclusive store status: 1 = suppressed |
| rsp_err | output | NREQ | Request rejected as malformed |

## Verification
Two exclusive stores from different requesters can land in the same cycle on the same shared word, each holding its global reservation. The bench provokes this by giving both requesters exclusive loads on the shared window and then driving both stores together. It then checks three things: the lower index reports success, the other reports failure, and a later read holds only the winner's data. A second overlap, exception clear in the cycle between load and store, is judged separately on local and global addresses.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int NREQ        = 2,
  parameter int AW          = 6,
  parameter int SHARED_BASE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_vld,
  input  logic [3*NREQ-1:0]    req_op,
  input  logic [2*NREQ-1:0]    req_size,
  input  logic [AW*NREQ-1:0]   req_addr,
  input  logic [32*NREQ-1:0]   req_wdata,
  input  logic [NREQ-1:0]      exc_clr,
  output logic [NREQ-1:0]      rsp_vld,
  output logic [32*NREQ-1:0]   rsp_rdata,
  output logic [NREQ-1:0]      rsp_fail,
  output logic [NREQ-1:0]      rsp_err
);
  localparam int MEM_BYTES = 1 << AW;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_LDX = 3'd2,
                         OP_STX = 3'd3, OP_CLR = 3'd4;

  logic [7:0]    mem [MEM_BYTES];
  logic [NREQ-1:0] loc_q, glb_q, loc_d, glb_d;
  logic [NREQ-1:0] wr_en, fail_d, err_d, ld_d;

  logic [2:0]    op_w [NREQ];
  logic [1:0]    sz_w [NREQ];
  logic [AW-1:0] ad_w [NREQ];
  logic [31:0]   wd_w [NREQ];
  logic [31:0]   rd_w [NREQ];
  logic [3:0]    be_w [NREQ];
  logic [NREQ-1:0] bad_w, sh_w;

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    assign op_w[i] = req_op[3*i +: 3];
    assign sz_w[i] = req_size[2*i +: 2];
    assign ad_w[i] = req_addr[AW*i +: AW];
    assign wd_w[i] = req_wdata[32*i +: 32];
    assign be_w[i] = (sz_w[i] == 2'd0) ? 4'b0001 :
                     (sz_w[i] == 2'd1) ? 4'b0011 : 4'b1111;
    assign bad_w[i] = (sz_w[i] == 2'd3) || (op_w[i] > OP_CLR) ||
                      (sz_w[i] == 2'd1 && ad_w[i][0]) ||
                      (sz_w[i] == 2'd2 && ad_w[i][1:0] != 2'b00);
    assign sh_w[i] = 32'(ad_w[i]) >= SHARED_BASE;
    for (genvar k = 0; k < 4; k++) begin : g_byte
      assign rd_w[i][8*k +: 8] = be_w[i][k] ? mem[ad_w[i] + AW'(k)] : 8'h00;
    end
  end

  always_comb begin
    loc_d  = loc_q;
    glb_d  = glb_q;
    wr_en  = '0;
    fail_d = '0;
    err_d  = '0;
    ld_d   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_vld[i]) begin
        if (bad_w[i]) begin
          err_d[i]  = 1'b1;
          fail_d[i] = (op_w[i] == OP_STX);
        end else begin
          case (op_w[i])
            OP_RD:  ld_d[i] = 1'b1;
            OP_WR:  wr_en[i] = 1'b1;
            OP_LDX: begin
              ld_d[i] = 1'b1;
              if (sh_w[i]) glb_d[i] = 1'b1;
              else         loc_d[i] = 1'b1;
            end
            OP_STX: begin
              if (sh_w[i]) begin
                if (glb_d[i]) begin
                  wr_en[i] = 1'b1;
                  glb_d    = '0;
                end else begin
                  fail_d[i] = 1'b1;
                end
              end else begin
                if (loc_d[i]) wr_en[i] = 1'b1;
                else          fail_d[i] = 1'b1;
                loc_d[i] = 1'b0;
              end
            end
            OP_CLR: begin
              loc_d[i] = 1'b0;
              glb_d[i] = 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
    loc_d = loc_d & ~exc_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q    <= '0;
      glb_q    <= '0;
      rsp_vld  <= '0;
      rsp_fail <= '0;
      rsp_err  <= '0;
      rsp_rdata <= '0;
    end else begin
      loc_q    <= loc_d;
      glb_q    <= glb_d;
      rsp_vld  <= req_vld;
      rsp_fail <= fail_d;
      rsp_err  <= err_d;
      for (int i = 0; i < NREQ; i++)
        rsp_rdata[32*i +: 32] <= ld_d[i] ? rd_w[i] : 32'h0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < MEM_BYTES; b++) mem[b] <= 8'h00;
    end else begin
      for (int i = NREQ - 1; i >= 0; i--)
        if (wr_en[i])
          for (int k = 0; k < 4; k++)
            if (be_w[i][k]) mem[ad_w[i] + AW'(k)] <= wd_w[i][8*k +: 8];
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int NREQ        = 2,
  parameter int AW          = 6,
  parameter int SHARED_BASE = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NREQ-1:0]     req_vld,
  input logic [3*NREQ-1:0]   req_op,
  input logic [2*NREQ-1:0]   req_size,
  input logic [AW*NREQ-1:0]  req_addr,
  input logic [NREQ-1:0]     exc_clr,
  input logic [NREQ-1:0]     rsp_vld,
  input logic [NREQ-1:0]     rsp_fail,
  input logic [NREQ-1:0]     rsp_err,
  input logic [NREQ-1:0]     loc_q,
  input logic [NREQ-1:0]     glb_q
);
  logic [NREQ-1:0] was_stx_sh, was_stx, glb_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_stx_sh <= '0;
      was_stx    <= '0;
    end else begin
      for (int i = 0; i < NREQ; i++) begin
        was_stx[i]    <= req_vld[i] && req_op[3*i +: 3] == 3'd3;
        was_stx_sh[i] <= req_vld[i] && req_op[3*i +: 3] == 3'd3 &&
                         32'(req_addr[AW*i +: AW]) >= SHARED_BASE;
      end
    end
  end

  assign glb_win = was_stx_sh & rsp_vld & ~rsp_fail & ~rsp_err;

  // R9
  one_global_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(glb_win) <= 1);

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    // R1
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld[i] |=> rsp_vld[i]);
    // R12
    fail_only_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fail[i] |-> was_stx[i]);
    // R11
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld[i] && req_size[2*i +: 2] == 2'd3) |=> rsp_err[i]);
    // R5
    clear_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld[i] && req_op[3*i +: 3] == 3'd4) |=> (rsp_err[i] || (!loc_q[i] && !glb_q[i])));
    // R6
    exc_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_clr[i] |=> !loc_q[i]);
  end
endmodule

bind excl_monitor excl_monitor_chk #(.NREQ(NREQ), .AW(AW), .SHARED_BASE(SHARED_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op), .req_size(req_size),
  .req_addr(req_addr), .exc_clr(exc_clr), .rsp_vld(rsp_vld), .rsp_fail(rsp_fail),
  .rsp_err(rsp_err), .loc_q(loc_q), .glb_q(glb_q));

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int NREQ = 2, AW = 6, SB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NREQ-1:0]    req_vld = '0, exc_clr = '0;
  logic [3*NREQ-1:0]  req_op = '0;
  logic [2*NREQ-1:0]  req_size = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [32*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0]    rsp_vld, rsp_fail, rsp_err;
  logic [32*NREQ-1:0] rsp_rdata;

  always #5 clk = ~clk;

  excl_monitor #(.NREQ(NREQ), .AW(AW), .SHARED_BASE(SB)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .exc_clr(exc_clr), .rsp_vld(rsp_vld),
    .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail), .rsp_err(rsp_err));

  logic [7:0] shadow [64];
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int a, input int sz);
    logic [31:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = shadow[(a + k) % 64];
    return v;
  endfunction

  task automatic set_req(input int r, input int op, input int sz, input int a, input logic [31:0] d);
    req_vld[r] = 1'b1;
    req_op[3*r +: 3] = 3'(op);
    req_size[2*r +: 2] = 2'(sz);
    req_addr[AW*r +: AW] = AW'(a);
    req_wdata[32*r +: 32] = d;
  endtask

  task automatic step();
    @(negedge clk);
    req_vld = '0;
    exc_clr = '0;
  endtask

  task automatic one(input int r, input int op, input int sz, input int a, input logic [31:0] d,
                     input bit efail, input bit eerr, input string req);
    logic [31:0] er;
    er = exp_rd(a, sz < 3 ? sz : 2);
    set_req(r, op, sz, a, d);
    step();
    chk(rsp_vld[r] === 1'b1, {req, " rsp_vld"}, 32'(rsp_vld[r]), 1);
    chk(rsp_fail[r] === efail, {req, " status"}, 32'(rsp_fail[r]), 32'(efail));
    chk(rsp_err[r] === eerr, {req, " err"}, 32'(rsp_err[r]), 32'(eerr));
    if ((op == 0 || op == 2) && !eerr)
      chk(rsp_rdata[32*r +: 32] === er, {req, " rdata"}, rsp_rdata[32*r +: 32], er);
    else if (op == 1 || op == 3)
      chk(rsp_rdata[32*r +: 32] === 32'h0, {req, " R12 rdata zero"}, rsp_rdata[32*r +: 32], 0);
    if ((op == 1 || (op == 3 && !efail)) && !eerr)
      for (int k = 0; k < (1 << sz); k++) shadow[a + k] = d[8*k +: 8];
  endtask

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int b = 0; b < 64; b++) shadow[b] = 8'h00;
    repeat (3) @(negedge clk);
    chk(rsp_vld === '0 && rsp_fail === '0 && rsp_err === '0, "reset outputs", 32'(rsp_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    one(0, 0, 2, 0, 0, 0, 0, "R10 reset memory read");

    // R1 R2 R3 sweep over requesters, sizes, regions and positions
    for (int r = 0; r < 2; r++)
      for (int sz = 0; sz < 3; sz++)
        for (int g = 0; g < 2; g++)
          for (int k = 0; k < 4; k++) begin
            int a;
            logic [31:0] d;
            a = (g == 1 ? SB : r * 16) + 4 * k + (sz == 0 ? k : (sz == 1 ? 2 * (k & 1) : 0));
            d = 32'hC3A50000 ^ 32'(r << 20) ^ 32'(sz << 12) ^ 32'(g << 8) ^ 32'(k * 8'h37);
            one(r, 2, sz, a, 0, 0, 0, "R1 exclusive load");
            one(r, 3, sz, a, d, 0, 0, "R2 exclusive store ok");
            one(r, 3, sz, a, ~d, 1, 0, "R3 store without tag");
            one(r, 0, sz, a, 0, 0, 0, "R2 readback");
          end

    // R4 address not compared
    one(0, 2, 2, 32, 0, 0, 0, "R4 load A");
    one(0, 2, 2, 40, 0, 0, 0, "R4 load B");
    one(0, 3, 2, 40, 32'h11112222, 0, 0, "R4 store B");
    one(0, 3, 2, 32, 32'h33334444, 1, 0, "R4 store A");
    one(1, 2, 1, 18, 0, 0, 0, "R4 private load A");
    one(1, 2, 1, 22, 0, 0, 0, "R4 private load B");
    one(1, 3, 1, 22, 32'h5151, 0, 0, "R4 private store B");
    one(1, 3, 1, 18, 32'h6161, 1, 0, "R4 private store A");

    // R5 clear request
    one(0, 2, 2, 36, 0, 0, 0, "R5 load");
    one(0, 4, 2, 36, 0, 0, 0, "R5 clear");
    one(0, 3, 2, 36, 32'hDEAD0001, 1, 0, "R5 store after clear");
    one(0, 2, 2, 4, 0, 0, 0, "R5 private load");
    one(0, 4, 2, 4, 0, 0, 0, "R5 private clear");
    one(0, 3, 2, 4, 32'hDEAD0002, 1, 0, "R5 private store after clear");
    one(0, 0, 2, 36, 0, 0, 0, "R5 memory untouched");

    // R6 exception clears local only
    one(0, 2, 2, 4, 0, 0, 0, "R6 local load");
    exc_clr[0] = 1'b1; step();
    one(0, 3, 2, 4, 32'hBEEF0004, 1, 0, "R6 local store after exception");
    one(0, 2, 2, 44, 0, 0, 0, "R6 global load");
    exc_clr[0] = 1'b1; step();
    one(0, 3, 2, 44, 32'hBEEF0044, 0, 0, "R6 global store after exception");
    one(1, 2, 2, 24, 0, 0, 0, "R6 other requester load");
    exc_clr[0] = 1'b1; step();
    one(1, 3, 2, 24, 32'hBEEF0024, 0, 0, "R6 other requester unaffected");

    // R7 private tags are per requester
    one(0, 2, 2, 8, 0, 0, 0, "R7 r0 load");
    one(1, 2, 2, 20, 0, 0, 0, "R7 r1 load");
    one(1, 3, 2, 20, 32'h7777AAAA, 0, 0, "R7 r1 store");
    one(0, 3, 2, 8, 32'h8888BBBB, 0, 0, "R7 r0 store keeps tag");

    // R8 global loss
    one(0, 2, 2, 48, 0, 0, 0, "R8 r0 load");
    one(1, 2, 2, 52, 0, 0, 0, "R8 r1 load");
    one(1, 3, 2, 52, 32'h0F0F0F0F, 0, 0, "R8 r1 store");
    one(0, 3, 2, 48, 32'hF0F0F0F0, 1, 0, "R8 r0 lost reservation");

    // R9 same-cycle stores to the shared window
    one(0, 2, 2, 56, 0, 0, 0, "R9 r0 load");
    one(1, 2, 2, 56, 0, 0, 0, "R9 r1 load");
    set_req(0, 3, 2, 56, 32'hAAAA0000);
    set_req(1, 3, 2, 56, 32'hBBBB1111);
    step();
    chk(rsp_fail[0] === 1'b0, "R9 r0 wins", 32'(rsp_fail[0]), 0);
    chk(rsp_fail[1] === 1'b1, "R9 r1 loses", 32'(rsp_fail[1]), 1);
    for (int k = 0; k < 4; k++) shadow[56 + k] = 8'(32'hAAAA0000 >> (8 * k));
    one(1, 0, 2, 56, 0, 0, 0, "R9 winner data");

    // R10 ordinary accesses leave tags alone
    one(0, 2, 2, 12, 0, 0, 0, "R10 load");
    one(0, 1, 2, 12, 32'h12345678, 0, 0, "R10 plain write");
    one(0, 0, 1, 14, 0, 0, 0, "R10 plain read");
    one(0, 3, 2, 12, 32'h9ABCDEF0, 0, 0, "R10 store still ok");
    one(0, 2, 2, 40, 0, 0, 0, "R10 global load");
    one(1, 1, 0, 41, 32'h5A, 0, 0, "R10 other plain write");
    one(0, 3, 2, 40, 32'h0BADF00D, 0, 0, "R10 global store still ok");

    // R11 malformed requests
    one(0, 2, 2, 0, 0, 0, 0, "R11 load");
    one(0, 3, 3, 0, 32'hFFFFFFFF, 1, 1, "R11 size 3 store");
    one(0, 3, 2, 2, 32'hEEEEEEEE, 1, 1, "R11 misaligned store");
    one(0, 7, 0, 0, 32'hEEEEEEEE, 0, 1, "R11 bad op");
    one(0, 1, 1, 33, 32'hCCCC, 0, 1, "R11 misaligned write");
    one(0, 3, 2, 0, 32'h01020304, 0, 0, "R11 tag survives error");
    one(0, 0, 2, 32, 0, 0, 0, "R11 memory untouched");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule